// File: doc/BRIEF.md
# Vector Floating-Point Compare Unit

The unit compares two 128-bit vector operands lane by lane under one of three IEEE predicates (equal, greater-than, greater-or-equal) and writes a per-lane mask into a destination vector register kept inside the block. The element format may be 32-bit (four lanes), 64-bit (two lanes) or 128-bit (one lane). Element 0 always occupies the most significant bits of a vector. An optional two-bit condition code sums up how many lanes matched.

Each request is one `start_i` pulse carrying the operands, the format, the predicate, two 4-bit modifier fields and an enhancement-enable input. The outcome appears one cycle later together with a one-cycle `valid_o`. A malformed request raises a specification exception and changes nothing. A NaN that signals raises an invalid-operation exception, reports the lane, and stops the lane scan. If the trap for that exception is enabled, the destination and the condition code keep their old values.

Top module: `vfp_cmp_unit`

## Requirements
- R1: Format code `fmt_i` = 0 gives four 32-bit lanes, 1 gives two 64-bit lanes and 2 gives one 128-bit lane. Lane k sits at bits [127-W*k : 128-W*(k+1)]. A matching lane writes all ones to its element and a lane that does not match writes all zeros.
- R2: Predicate `pred_i` = 0 (equal) is true when neither operand is a NaN and the operands are bit-identical or both are zeros of any sign.
- R3: Predicate 1 is true when A > B and predicate 2 is true when A >= B. Both are ordered signed comparisons, false when either operand is a NaN, and zeros of opposite sign are equal.
- R4: The condition code is 0 when every processed lane matched, 1 when some but not all matched, and 3 when none matched. It is never 2.
- R5: When `mode_i[3]` (single element) is set, only lane 0 is compared and every other result element is zero. A match then gives code 0 and no match gives code 3.
- R6: When `mode_i[2]` is clear, only a signalling NaN (quiet bit, the top fraction bit, clear) raises invalid-operation. When it is set, any NaN operand raises it.
- R7: Lanes are evaluated from lane 0 upward. The first lane that raises invalid-operation ends the scan. That lane's index appears on `exc_lane_o`, and all later lanes are written as zero.
- R8: When invalid-operation is raised while `inv_trap_en_i` is 1, the result and the condition code are left unchanged. When `inv_trap_en_i` is 0, both are written in full.
- R9: A specification exception is raised, and neither the result nor the condition code changes, in any of these cases: `mode_i[1:0]` is nonzero, `cc_ctl_i[3:1]` is nonzero, the format code is 3, the predicate code is 3, or single-element mode is used with the 128-bit format.
- R10: With `enh_i` = 0, any format other than 64-bit, or a set `mode_i[2]`, is a specification exception.
- R11: The condition code is written only when `cc_ctl_i[0]` is 1.
- R12: After reset the result and the condition code are zero and no valid or exception output is asserted. `valid_o` rises exactly one cycle after `start_i`, and the exception flags are meaningful only while `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| op_a_i | input | 128 | First operand vector (A) |
| op_b_i | input | 128 | Second operand vector (B) |
| fmt_i | input | 2 | Element format: 0 = 32, 1 = 64, 2 = 128 bit |
| pred_i | input | 2 | Predicate: 0 = equal, 1 = greater, 2 = greater-or-equal |
| mode_i | input | 4 | Bit 3 single element, bit 2 signal on quiet NaN, bits 1:0 reserved |
| cc_ctl_i | input | 4 | Bit 0 updates the condition code, bits 3:1 reserved |
| enh_i | input | 1 | Enables the extended formats and signal-on-quiet-NaN |
| inv_trap_en_i | input | 1 | Invalid-operation trap enabled |
| valid_o | output | 1 | Result strobe, one cycle after start |
| result_o | output | 128 | Destination mask vector |
| cc_o | output | 2 | Condition code |
| spec_exc_o | output | 1 | Specification exception (with valid) |
| inv_exc_o | output | 1 | Invalid-operation exception (with valid) |
| exc_lane_o | output | 2 | Lane that raised invalid-operation |

## Verification
A faulty lane scan or stop point shows up on the first strobe after the faulty request. It appears as a mask element that should have stayed zero, a wrong lane index, or a code of 1 where 0 or 3 was due. State kept across requests, meaning the destination and the condition code, can only be seen by the next request that leaves them alone. For that reason every trapped, specification-failed or code-suppressed request follows one with a distinct known outcome, so a wrongful write is caught within a single request.

// File: rtl/vfc_pkg.sv
// Shared constants and types for the vector FP compare unit.
// Assumes a 128-bit vector and the three IEEE binary formats 32/64/128.
package vfc_pkg;
    localparam int VEC_W     = 128;
    localparam int S_W       = 32;
    localparam int D_W       = 64;
    localparam int Q_W       = 128;
    localparam int S_EW      = 8;
    localparam int D_EW      = 11;
    localparam int Q_EW      = 15;
    localparam int S_LANES   = VEC_W / S_W;
    localparam int D_LANES   = VEC_W / D_W;
    localparam int MAX_LANES = S_LANES;
    localparam int LANE_W    = $clog2(MAX_LANES);
    localparam int CNT_W     = LANE_W + 1;

    typedef enum logic [1:0] {FMT_S = 2'd0, FMT_D = 2'd1, FMT_Q = 2'd2, FMT_BAD = 2'd3} fmt_e;
    typedef enum logic [1:0] {PRED_EQ = 2'd0, PRED_GT = 2'd1, PRED_GE = 2'd2, PRED_BAD = 2'd3} pred_e;

    typedef struct packed {
        logic single;
        logic sig_q;
        logic set_cc;
        logic spec;
    } ctrl_t;
endpackage

// File: rtl/vfc_decode.sv
// Modifier decode: extracts the mode bits and flags illegal combinations.
// Assumes purely combinational use; the caller samples the result on start.
module vfc_decode
    import vfc_pkg::*;
(
    input  fmt_e        fmt_i,
    input  pred_e       pred_i,
    input  logic [3:0]  mode_i,
    input  logic [3:0]  cc_ctl_i,
    input  logic        enh_i,
    output ctrl_t       ctrl_o
);
    // Decode control bits and the specification check.
    always_comb begin
        ctrl_o.single = mode_i[3];
        ctrl_o.sig_q  = mode_i[2];
        ctrl_o.set_cc = cc_ctl_i[0];
        ctrl_o.spec   = (mode_i[1:0] != 2'b00) || (cc_ctl_i[3:1] != 3'b000)
                     || (fmt_i == FMT_BAD) || (pred_i == PRED_BAD)
                     || (mode_i[3] && fmt_i == FMT_Q)
                     || (!enh_i && (fmt_i != FMT_D || mode_i[2]));
    end
endmodule

// File: rtl/vfc_fp_cmp.sv
// One IEEE binary compare of width W with EW exponent bits.
// hit = A pred B (ordered); invalid flags signalling NaNs, or any NaN when sig_q.
module vfc_fp_cmp
    import vfc_pkg::*;
#(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  pred_e        pred_i,
    input  logic         sig_q_i,
    output logic         hit_o,
    output logic         invalid_o
);
    localparam int MW = W - EW - 1;

    logic nan_a, nan_b, snan_a, snan_b, any_nan, both_zero, b_lt_a, equal;

    // Classify operands and evaluate the ordered relations.
    always_comb begin
        nan_a     = (&a_i[W-2 -: EW]) && (|a_i[MW-1:0]);
        nan_b     = (&b_i[W-2 -: EW]) && (|b_i[MW-1:0]);
        snan_a    = nan_a && !a_i[MW-1];
        snan_b    = nan_b && !b_i[MW-1];
        any_nan   = nan_a || nan_b;
        both_zero = (a_i[W-2:0] == '0) && (b_i[W-2:0] == '0);
        equal     = both_zero || (a_i == b_i);
        if (both_zero)
            b_lt_a = 1'b0;
        else if (a_i[W-1] != b_i[W-1])
            b_lt_a = b_i[W-1];
        else if (!b_i[W-1])
            b_lt_a = b_i[W-2:0] < a_i[W-2:0];
        else
            b_lt_a = b_i[W-2:0] > a_i[W-2:0];
        unique case (pred_i)
            PRED_EQ: hit_o = !any_nan && equal;
            PRED_GT: hit_o = !any_nan && b_lt_a;
            PRED_GE: hit_o = !any_nan && (b_lt_a || equal);
            default: hit_o = 1'b0;
        endcase
        invalid_o = snan_a || snan_b || (sig_q_i && any_nan);
    end
endmodule

// File: rtl/vfc_lane_bank.sv
// Compare lanes for every format, muxed onto a common lane view by format.
// Lane 0 is the most significant element of each vector.
module vfc_lane_bank
    import vfc_pkg::*;
(
    input  logic [VEC_W-1:0]     a_i,
    input  logic [VEC_W-1:0]     b_i,
    input  fmt_e                 fmt_i,
    input  pred_e                pred_i,
    input  logic                 sig_q_i,
    output logic [MAX_LANES-1:0] hit_o,
    output logic [MAX_LANES-1:0] inv_o,
    output logic [CNT_W-1:0]     n_lanes_o
);
    logic [S_LANES-1:0] hit_s, inv_s;
    logic [D_LANES-1:0] hit_d, inv_d;
    logic               hit_q, inv_q;

    for (genvar g = 0; g < S_LANES; g++) begin : g_s
        vfc_fp_cmp #(.W(S_W), .EW(S_EW)) u_cmp (
            .a_i(a_i[VEC_W-1-S_W*g -: S_W]), .b_i(b_i[VEC_W-1-S_W*g -: S_W]),
            .pred_i(pred_i), .sig_q_i(sig_q_i), .hit_o(hit_s[g]), .invalid_o(inv_s[g]));
    end
    for (genvar g = 0; g < D_LANES; g++) begin : g_d
        vfc_fp_cmp #(.W(D_W), .EW(D_EW)) u_cmp (
            .a_i(a_i[VEC_W-1-D_W*g -: D_W]), .b_i(b_i[VEC_W-1-D_W*g -: D_W]),
            .pred_i(pred_i), .sig_q_i(sig_q_i), .hit_o(hit_d[g]), .invalid_o(inv_d[g]));
    end
    vfc_fp_cmp #(.W(Q_W), .EW(Q_EW)) u_cmp_q (
        .a_i(a_i), .b_i(b_i), .pred_i(pred_i), .sig_q_i(sig_q_i),
        .hit_o(hit_q), .invalid_o(inv_q));

    // Select the lane flags and lane count of the active format.
    always_comb begin
        hit_o     = '0;
        inv_o     = '0;
        n_lanes_o = '0;
        unique case (fmt_i)
            FMT_S: begin
                hit_o[S_LANES-1:0] = hit_s;
                inv_o[S_LANES-1:0] = inv_s;
                n_lanes_o          = CNT_W'(S_LANES);
            end
            FMT_D: begin
                hit_o[D_LANES-1:0] = hit_d;
                inv_o[D_LANES-1:0] = inv_d;
                n_lanes_o          = CNT_W'(D_LANES);
            end
            FMT_Q: begin
                hit_o[0]  = hit_q;
                inv_o[0]  = inv_q;
                n_lanes_o = CNT_W'(1);
            end
            default: n_lanes_o = '0;
        endcase
    end
endmodule

// File: rtl/vfp_cmp_unit.sv
// Vector FP compare unit top: decode, lane compare, ordered scan with
// stop-at-first-exception, condition-code summary and result registers.
// Assumes one request per start pulse; outcome is strobed one cycle later.
module vfp_cmp_unit
    import vfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [VEC_W-1:0]   op_a_i,
    input  logic [VEC_W-1:0]   op_b_i,
    input  logic [1:0]         fmt_i,
    input  logic [1:0]         pred_i,
    input  logic [3:0]         mode_i,
    input  logic [3:0]         cc_ctl_i,
    input  logic               enh_i,
    input  logic               inv_trap_en_i,
    output logic               valid_o,
    output logic [VEC_W-1:0]   result_o,
    output logic [1:0]         cc_o,
    output logic               spec_exc_o,
    output logic               inv_exc_o,
    output logic [LANE_W-1:0]  exc_lane_o
);
    fmt_e  fmt;
    pred_e pred;
    ctrl_t ctrl;
    logic [MAX_LANES-1:0] lane_hit, lane_inv, keep;
    logic [CNT_W-1:0]     n_lanes, n_proc, cnt;
    logic                 stop, inv_any;
    logic [LANE_W-1:0]    inv_lane;
    logic [1:0]           cc_new;
    logic [VEC_W-1:0]     res_new;

    assign fmt  = fmt_e'(fmt_i);
    assign pred = pred_e'(pred_i);

    vfc_decode u_dec (
        .fmt_i(fmt), .pred_i(pred), .mode_i(mode_i), .cc_ctl_i(cc_ctl_i),
        .enh_i(enh_i), .ctrl_o(ctrl));

    vfc_lane_bank u_bank (
        .a_i(op_a_i), .b_i(op_b_i), .fmt_i(fmt), .pred_i(pred),
        .sig_q_i(ctrl.sig_q), .hit_o(lane_hit), .inv_o(lane_inv), .n_lanes_o(n_lanes));

    // Scan lanes upward, stopping at the first invalid-operation lane.
    always_comb begin
        n_proc   = ctrl.single ? CNT_W'(1) : n_lanes;
        keep     = '0;
        cnt      = '0;
        stop     = 1'b0;
        inv_any  = 1'b0;
        inv_lane = '0;
        for (int i = 0; i < MAX_LANES; i++) begin
            if (CNT_W'(i) < n_proc && !stop) begin
                if (lane_hit[i]) begin
                    keep[i] = 1'b1;
                    cnt     = cnt + CNT_W'(1);
                end
                if (lane_inv[i]) begin
                    stop     = 1'b1;
                    inv_any  = 1'b1;
                    inv_lane = LANE_W'(i);
                end
            end
        end
        if (cnt == '0)
            cc_new = 2'd3;
        else if (cnt == n_proc)
            cc_new = 2'd0;
        else
            cc_new = 2'd1;
    end

    // Expand the kept lane flags into element masks for the active format.
    always_comb begin
        res_new = '0;
        unique case (fmt)
            FMT_S: for (int i = 0; i < S_LANES; i++)
                       res_new[VEC_W-1-S_W*i -: S_W] = {S_W{keep[i]}};
            FMT_D: for (int i = 0; i < D_LANES; i++)
                       res_new[VEC_W-1-D_W*i -: D_W] = {D_W{keep[i]}};
            default: res_new = {VEC_W{keep[0]}};
        endcase
    end

    // Register the outcome and commit the destination and condition code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            result_o   <= '0;
            cc_o       <= '0;
            spec_exc_o <= 1'b0;
            inv_exc_o  <= 1'b0;
            exc_lane_o <= '0;
        end else begin
            valid_o    <= start_i;
            spec_exc_o <= start_i && ctrl.spec;
            inv_exc_o  <= start_i && !ctrl.spec && inv_any;
            if (start_i && !ctrl.spec) begin
                exc_lane_o <= inv_lane;
                if (!(inv_any && inv_trap_en_i)) begin
                    result_o <= res_new;
                    if (ctrl.set_cc)
                        cc_o <= cc_new;
                end
            end
        end
    end

    // R12: a result strobe follows every start one cycle later.
    assert_valid_after_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
    // R12: no strobe without a preceding start.
    assert_no_spurious_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(start_i));
    // R4: the code 2 is never produced.
    assert_cc_not_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cc_o != 2'd2);
    // R9: a specification exception leaves destination and code untouched.
    assert_spec_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && spec_exc_o) |-> ($stable(result_o) && $stable(cc_o)));
    // R9: specification and invalid-operation are never reported together.
    assert_exc_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spec_exc_o, inv_exc_o}));
    // R8: a trapped invalid operation writes nothing.
    assert_trap_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && inv_exc_o && $past(inv_trap_en_i)) |-> ($stable(result_o) && $stable(cc_o)));
    // R11: with the set-code bit clear the condition code holds.
    assert_cc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(!cc_ctl_i[0])) |-> $stable(cc_o));
    // R5: single-element mode leaves the lower elements zero when it writes.
    assert_single_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !spec_exc_o && $past(mode_i[3] && !inv_trap_en_i)) |-> (result_o[D_W-1:0] == '0));
endmodule

// File: tb/tb_vfp_cmp_unit.sv
// Scoreboard bench: driver pushes expected outcomes, monitor pops and compares.
module tb_vfp_cmp_unit;
    localparam logic [31:0] S1 = 32'h3F80_0000, S2 = 32'h4000_0000, SM1 = 32'hBF80_0000;
    localparam logic [31:0] SPZ = 32'h0, SMZ = 32'h8000_0000, SQN = 32'h7FC0_0000;
    localparam logic [31:0] SSN = 32'h7FA0_0000, SINF = 32'h7F80_0000;
    localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
    localparam logic [63:0] DM1 = 64'hBFF0_0000_0000_0000, DM2 = 64'hC000_0000_0000_0000;
    localparam logic [63:0] DSN = 64'h7FF4_0000_0000_0000;
    localparam logic [31:0] F = 32'hFFFF_FFFF, Z = 32'h0;

    typedef struct {
        logic [127:0] res;
        logic [1:0]   cc;
        logic         spec;
        logic         inv;
        logic [1:0]   lane;
        string        tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [127:0] a = '0, b = '0;
    logic [1:0] fmt = '0, pred = '0;
    logic [3:0] mode = '0, ccc = '0;
    logic enh = 1'b1, trap = 1'b0;
    logic valid, spec, inv;
    logic [127:0] res;
    logic [1:0] cc, lane;
    int checks = 0, fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    vfp_cmp_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_a_i(a), .op_b_i(b),
        .fmt_i(fmt), .pred_i(pred), .mode_i(mode), .cc_ctl_i(ccc), .enh_i(enh),
        .inv_trap_en_i(trap), .valid_o(valid), .result_o(res), .cc_o(cc),
        .spec_exc_o(spec), .inv_exc_o(inv), .exc_lane_o(lane));

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic op(input logic [1:0] f, input logic [1:0] p, input logic [3:0] m5,
                      input logic [3:0] m6, input logic en, input logic tr,
                      input logic [127:0] va, input logic [127:0] vb,
                      input logic [127:0] eres, input logic [1:0] ecc, input logic esp,
                      input logic einv, input logic [1:0] elane, input string tag);
        exp_t e;
        e.res = eres; e.cc = ecc; e.spec = esp; e.inv = einv; e.lane = elane; e.tag = tag;
        @(negedge clk);
        fmt = f; pred = p; mode = m5; ccc = m6; enh = en; trap = tr; a = va; b = vb;
        start = 1'b1;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare each strobed outcome with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R12", "unexpected valid", 128'(valid), 128'(0));
            end else begin
                exp_t e;
                e = q.pop_front();
                check(res === e.res, e.tag, "result", res, e.res);
                check(cc === e.cc, e.tag, "cc", 128'(cc), 128'(e.cc));
                check(spec === e.spec, e.tag, "spec_exc", 128'(spec), 128'(e.spec));
                check(inv === e.inv, e.tag, "inv_exc", 128'(inv), 128'(e.inv));
                if (e.inv)
                    check(lane === e.lane, e.tag, "lane", 128'(lane), 128'(e.lane));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(res === '0, "R12", "reset result", res, '0);
        check(cc === 2'd0, "R12", "reset cc", 128'(cc), 128'(0));
        check({valid, spec, inv} === 3'b0, "R12", "reset strobes", 128'({valid, spec, inv}), 128'(0));
        rst_n = 1'b1;
        // R2 R1: equal, +/-0 equal, quiet NaN false without exception
        op(0, 0, 4'h0, 4'h1, 1, 0, {S1, S2, SPZ, SQN}, {S1, S1, SMZ, SQN},
           {F, Z, F, Z}, 1, 0, 0, 0, "R2");
        // R3: greater-than
        op(0, 1, 4'h0, 4'h1, 1, 0, {S2, SM1, S1, SINF}, {S1, S1, S1, S2},
           {F, Z, Z, F}, 1, 0, 0, 0, "R3");
        // R3: greater-or-equal
        op(0, 2, 4'h0, 4'h1, 1, 0, {S2, SM1, S1, SINF}, {S1, S1, S1, S2},
           {F, F, F, F} & {F, Z, F, F}, 1, 0, 0, 0, "R3");
        // R4: all lanes match -> 0
        op(1, 1, 4'h0, 4'h1, 1, 0, {D2, D1}, {D1, DM2}, {4{F}}, 0, 0, 0, 0, "R4");
        // R4: no lane matches -> 3
        op(1, 0, 4'h0, 4'h1, 1, 0, {D1, D2}, {D2, D1}, '0, 3, 0, 0, 0, "R4");
        // R8: trapped invalid keeps result and cc
        op(1, 0, 4'h0, 4'h1, 1, 1, {D1, DSN}, {D1, D1}, '0, 3, 0, 1, 1, "R8");
        // R3: negative operands
        op(1, 1, 4'h0, 4'h1, 1, 0, {DM1, DM2}, {DM2, DM1}, {F, F, Z, Z}, 1, 0, 0, 0, "R3");
        // R1: 128-bit single lane
        op(2, 2, 4'h0, 4'h1, 1, 0, {32'h4000_0000, Z, Z, Z}, {32'h3FFF_0000, Z, Z, Z},
           {4{F}}, 0, 0, 0, 0, "R1");
        // R5: single element, match
        op(0, 0, 4'h8, 4'h1, 1, 0, {S1, S2, S2, S2}, {S1, S2, S2, S2},
           {F, Z, Z, Z}, 0, 0, 0, 0, "R5");
        // R5: single element, no match
        op(1, 0, 4'h8, 4'h1, 1, 0, {D1, D1}, {D2, D1}, '0, 3, 0, 0, 0, "R5");
        // R6 R7: signal on quiet NaN stops at lane 1
        op(0, 0, 4'h4, 4'h1, 1, 0, {S1, SQN, S1, S1}, {4{S1}},
           {F, Z, Z, Z}, 1, 0, 1, 1, "R6");
        // R7: signalling NaN stops at lane 2, later lanes zero
        op(0, 2, 4'h0, 4'h1, 1, 0, {S1, S1, SSN, S1}, {4{S1}},
           {F, F, Z, Z}, 1, 0, 1, 2, "R7");
        // R11: set-cc clear keeps cc
        op(0, 0, 4'h0, 4'h0, 1, 0, {4{S1}}, {4{S1}}, {4{F}}, 1, 0, 0, 0, "R11");
        // R9: reserved mode bit
        op(0, 0, 4'h1, 4'h1, 1, 0, {4{S2}}, {4{S1}}, {4{F}}, 1, 1, 0, 0, "R9");
        // R9: single with 128-bit format
        op(2, 0, 4'h8, 4'h1, 1, 0, '0, '1, {4{F}}, 1, 1, 0, 0, "R9");
        // R9: predicate code 3
        op(1, 3, 4'h0, 4'h1, 1, 0, {D2, D2}, {D1, D1}, {4{F}}, 1, 1, 0, 0, "R9");
        // R9: reserved cc-control bit
        op(1, 0, 4'h0, 4'h2, 1, 0, {D2, D2}, {D1, D1}, {4{F}}, 1, 1, 0, 0, "R9");
        // R10: 32-bit without enhancement
        op(0, 0, 4'h0, 4'h1, 0, 0, {4{S2}}, {4{S1}}, {4{F}}, 1, 1, 0, 0, "R10");
        // R10: signal-on-quiet-NaN without enhancement
        op(1, 0, 4'h4, 4'h1, 0, 0, {D2, D2}, {D1, D1}, {4{F}}, 1, 1, 0, 0, "R10");
        // R10: 64-bit without enhancement is legal
        op(1, 0, 4'h0, 4'h1, 0, 0, {D1, D1}, {D1, D2}, {F, F, Z, Z}, 1, 0, 0, 0, "R10");
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R12", "pending results", 128'(q.size()), 128'(0));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule